// File: doc/BRIEF.md
# Phased Two-Stage Set-Associative Data Cache

This block is a 4-way set-associative data cache whose lookup is split into two pipeline stages so that the tag compare and the data array access never share a clock cycle. In the first stage the set index is decoded, the tags and valid bits of all four ways are read and compared with the request tag, and the resulting one-hot hit vector is registered. In the second stage only the data array of the way named by that vector is enabled, for a read or for a byte-masked write. The other three data arrays stay idle, so about a quarter of the data storage toggles per access.

A request may be issued every cycle. Its response, carrying the hit flag and the load data, appears two cycles after the request. A forwarding flag marks load hits so that the execute stage can take the data straight from the response. On a miss nothing is allocated by the cache itself: an outside agent installs the line through the refill port. The refill goes into the way named by a round-robin pointer kept for each set.

Top module: `phased_cache`

## Requirements
- R1: Reset clears every valid bit and every replacement pointer. While reset is held and in the first cycle after it, `rsp_valid` and `data_way_en` are 0. Any access issued after reset misses until a refill has installed its line.
- R2: A request presented in cycle t yields exactly one response with `rsp_valid` high in cycle t+2, and there is no response without such a request.
- R3: In cycle t+1 after a hitting request, `data_way_en` is the one-hot code of the hitting way. Bit k stands for way k.
- R4: A missing request asserts no bit of `data_way_en` in cycle t+1. Its response has `rsp_hit` low and `rsp_rdata` equal to 0.
- R5: A load hit returns the 32-bit word chosen by address bits [3:2] of the line, and raises `fwd_valid`. Address bits [7:4] select one of 16 sets and bits [31:8] form the tag.
- R6: A store hit writes byte i of the word (bits 8i+7..8i) only where strobe bit i is 1, in the hitting way. Its response has `rsp_hit` high, `rsp_rdata` 0 and `fwd_valid` low. A store with all strobes 0 leaves the word unchanged.
- R7: A store miss allocates nothing, so a later load to that line still misses.
- R8: A refill writes all four words of the line, where word k is taken from `refill_line` bits 32k+31..32k. It also writes the tag and sets the valid bit in the way named by the set's pointer. The pointer starts at way 0 and advances 0, 1, 2, 3, 0 with each refill to that set, so the fifth refill to a set evicts the first.
- R9: A load issued in the cycle right after a store to the same word returns the stored bytes, with no stall.
- R10: A request to a line that is being refilled in the same cycle hits the refilled line.
- R11: At most one bit of `data_way_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| req_strb | input | 4 | Store byte strobes |
| refill_valid | input | 1 | Install a line this cycle |
| refill_addr | input | 32 | Address of the line to install |
| refill_line | input | 128 | Line data, word k at bits 32k+31..32k |
| data_way_en | output | 4 | Per-way data array enable of stage two |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response hit flag |
| rsp_rdata | output | 32 | Load data, 0 for stores and misses |
| fwd_valid | output | 1 | Response carries load data for forwarding |

## Verification
The hit vector is registered one clock edge after the request. For this reason the bench checks `data_way_en` in cycle t+1, and it checks the response fields in cycle t+2. A behavioural reference model sits in the bench. Each cycle it first retires the access in its stage two, then applies any refill, and then looks up the new request, which is the same order in which the design updates at one clock edge. The bench drives its inputs and samples the outputs on the falling edge, so each expected value is compared in the exact cycle that the requirement names.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

    localparam int unsigned PC_ADDR_W     = 32;
    localparam int unsigned PC_DATA_W     = 32;
    localparam int unsigned PC_WAYS       = 4;
    localparam int unsigned PC_SETS       = 16;
    localparam int unsigned PC_LINE_WORDS = 4;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/pc_tag_lookup.sv
module pc_tag_lookup #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 16,
    parameter int unsigned TAG_W = 24,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             refill_valid,
    input  logic [IDX_W-1:0] refill_idx,
    input  logic [TAG_W-1:0] refill_tag,
    output logic [WAYS-1:0]  hit_way,
    output logic [WAYS-1:0]  refill_way
);

    logic [TAG_W-1:0] tag_q [WAYS][SETS];
    logic [TAG_W-1:0] tag_d [WAYS][SETS];
    logic             vld_q [WAYS][SETS];
    logic             vld_d [WAYS][SETS];
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] ptr_d [SETS];
    logic [WAY_W-1:0] victim;

    assign victim = ptr_q[refill_idx];

    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        ptr_d = ptr_q;
        if (refill_valid) begin
            tag_d[victim][refill_idx] = refill_tag;
            vld_d[victim][refill_idx] = 1'b1;
            if (victim == WAY_W'(WAYS - 1)) begin
                ptr_d[refill_idx] = '0;
            end else begin
                ptr_d[refill_idx] = victim + 1'b1;
            end
        end
    end

    // Compare against next-state tags so a same-cycle refill is seen at once.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_way[w]    = req_valid && vld_d[w][req_idx]
                               && (tag_d[w][req_idx] == req_tag);
        assign refill_way[w] = refill_valid && (victim == WAY_W'(w));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '{default: '0};
            ptr_q <= '{default: '0};
        end else begin
            tag_q <= tag_d;
            vld_q <= vld_d;
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/pc_data_way.sv
module pc_data_way #(
    parameter int unsigned SETS       = 16,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned DATA_W     = 32,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned WORD_W = $clog2(LINE_WORDS),
    localparam int unsigned BYTES  = DATA_W / 8,
    localparam int unsigned LINE_W = LINE_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [BYTES-1:0]  acc_strb,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [SETS][LINE_WORDS];
    logic [DATA_W-1:0] mem_d [SETS][LINE_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (acc_en && acc_we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (acc_strb[b]) begin
                    mem_d[acc_idx][acc_word][8*b +: 8] = acc_wdata[8*b +: 8];
                end
            end
        end
        // A refill lands after the store so the newer line wins.
        if (fill_en) begin
            for (int k = 0; k < LINE_WORDS; k++) begin
                mem_d[fill_idx][k] = fill_line[k*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata = acc_en ? mem_q[acc_idx][acc_word] : '0;

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/phased_cache.sv
module phased_cache
    import pcache_pkg::*;
#(
    parameter int unsigned ADDR_W     = PC_ADDR_W,
    parameter int unsigned DATA_W     = PC_DATA_W,
    parameter int unsigned WAYS       = PC_WAYS,
    parameter int unsigned SETS       = PC_SETS,
    parameter int unsigned LINE_WORDS = PC_LINE_WORDS,
    localparam int unsigned BYTES  = DATA_W / 8,
    localparam int unsigned LINE_W = LINE_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BYTES-1:0]  req_strb,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_addr,
    input  logic [LINE_W-1:0] refill_line,
    output logic [WAYS-1:0]   data_way_en,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fwd_valid
);

    localparam int unsigned OFF_W  = $clog2(BYTES);
    localparam int unsigned WORD_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned IDX_LO = OFF_W + WORD_W;
    localparam int unsigned TAG_W  = ADDR_W - IDX_LO - IDX_W;

    typedef struct packed {
        logic              vld;
        acc_kind_e         kind;
        logic [WAYS-1:0]   way;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  strb;
    } stage2_t;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              load;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    typedef struct packed {
        stage2_t s2;
        resp_t   rsp;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [IDX_W-1:0]  req_idx, refill_idx;
    logic [TAG_W-1:0]  req_tag, refill_tag;
    logic [WAYS-1:0]   hit_way, refill_way;
    logic [DATA_W-1:0] way_rd [WAYS];
    logic [DATA_W-1:0] way_rdata;
    logic              addr_lo_unused;

    assign req_idx    = req_addr[IDX_LO +: IDX_W];
    assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
    assign refill_idx = refill_addr[IDX_LO +: IDX_W];
    assign refill_tag = refill_addr[ADDR_W-1 -: TAG_W];
    assign addr_lo_unused = ^{refill_addr[IDX_LO-1:0], req_addr[OFF_W-1:0]};

    pc_tag_lookup #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_idx      (req_idx),
        .req_tag      (req_tag),
        .refill_valid (refill_valid),
        .refill_idx   (refill_idx),
        .refill_tag   (refill_tag),
        .hit_way      (hit_way),
        .refill_way   (refill_way)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        pc_data_way #(
            .SETS       (SETS),
            .LINE_WORDS (LINE_WORDS),
            .DATA_W     (DATA_W)
        ) u_way (
            .clk       (clk),
            .acc_en    (pipe_q.s2.way[w]),
            .acc_we    (pipe_q.s2.kind == ACC_STORE),
            .acc_idx   (pipe_q.s2.idx),
            .acc_word  (pipe_q.s2.word),
            .acc_wdata (pipe_q.s2.wdata),
            .acc_strb  (pipe_q.s2.strb),
            .fill_en   (refill_way[w]),
            .fill_idx  (refill_idx),
            .fill_line (refill_line),
            .rdata     (way_rd[w])
        );
    end

    always_comb begin
        way_rdata = '0;
        for (int w = 0; w < WAYS; w++) begin
            way_rdata |= way_rd[w];
        end
    end

    always_comb begin
        pipe_d = pipe_q;
        // stage one: register the lookup result
        pipe_d.s2.vld   = req_valid;
        pipe_d.s2.kind  = !req_valid ? ACC_NONE : (req_we ? ACC_STORE : ACC_LOAD);
        pipe_d.s2.way   = hit_way;
        pipe_d.s2.idx   = req_idx;
        pipe_d.s2.word  = req_addr[OFF_W +: WORD_W];
        pipe_d.s2.wdata = req_wdata;
        pipe_d.s2.strb  = req_strb;
        // stage two: access the single enabled way, form the response
        pipe_d.rsp.vld  = pipe_q.s2.vld;
        pipe_d.rsp.hit  = |pipe_q.s2.way;
        pipe_d.rsp.load = pipe_q.s2.kind == ACC_LOAD;
        pipe_d.rsp.rdata = (pipe_d.rsp.hit && pipe_d.rsp.load) ? way_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign data_way_en = pipe_q.s2.way;
    assign rsp_valid   = pipe_q.rsp.vld;
    assign rsp_hit     = pipe_q.rsp.hit;
    assign rsp_rdata   = pipe_q.rsp.rdata;
    assign fwd_valid   = pipe_q.rsp.vld && pipe_q.rsp.hit && pipe_q.rsp.load;

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [WAYS-1:0]   data_way_en,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              fwd_valid
);

    AST_SINGLE_WAY_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_way_en))
        else $error("more than one data way enabled"); // R11

    AST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid)
        else $error("response missing two cycles after request"); // R2

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2))
        else $error("response without request"); // R2

    AST_EN_MEANS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_way_en != '0) |=> (rsp_valid && rsp_hit))
        else $error("enabled way did not produce a hit"); // R3

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> ($past(data_way_en) == '0 && rsp_rdata == '0))
        else $error("miss drove a data way or data"); // R4

    AST_FWD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (rsp_valid && rsp_hit))
        else $error("forward without a hit response"); // R5

endmodule

bind phased_cache pc_checker #(
    .WAYS   (WAYS),
    .DATA_W (DATA_W)
) u_pc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .data_way_en (data_way_en),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_rdata   (rsp_rdata),
    .fwd_valid   (fwd_valid)
);

// File: tb/phased_cache_test.sv
`timescale 1ns/1ps
module phased_cache_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_we, refill_valid;
    logic [31:0]  req_addr, req_wdata, refill_addr;
    logic [3:0]   req_strb;
    logic [127:0] refill_line;
    logic [3:0]   data_way_en;
    logic         rsp_valid, rsp_hit, fwd_valid;
    logic [31:0]  rsp_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    phased_cache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
        .req_wdata(req_wdata), .req_strb(req_strb),
        .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_line(refill_line),
        .data_way_en(data_way_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .fwd_valid(fwd_valid)
    );

    // reference cache
    logic [23:0] m_tag  [4][16];
    logic        m_vld  [4][16];
    logic [31:0] m_data [4][16][4];
    int          m_ptr  [16];
    // reference pipeline
    bit          s2_v;
    bit          s2_st;
    int          s2_way, s2_idx, s2_word, s2_rq, s2_exph;
    logic [31:0] s2_wd;
    logic [3:0]  s2_sb;
    bit          r_v, r_hit, r_fwd;
    logic [31:0] r_data;
    int          r_rq, r_exph;

    task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++) m_vld[w][s] = 1'b0;
        for (int s = 0; s < 16; s++) m_ptr[s] = 0;
        s2_v = 0; s2_way = -1; r_v = 0; r_hit = 0; r_fwd = 0; r_data = '0;
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_strb = '0;
        refill_valid = 0; refill_addr = '0; refill_line = '0;
    endtask

    // One cycle: check outputs at the falling edge, drive, update model, advance.
    task automatic step(input bit rv, input bit rw, input logic [31:0] ra, input logic [31:0] wd,
                        input logic [3:0] sb, input bit fv, input logic [31:0] fa,
                        input logic [31:0] seed, input int rq, input int exph);
        logic [3:0] exp_en;
        int fi, w;
        exp_en = (s2_v && s2_way >= 0) ? 4'(1 << s2_way) : 4'h0;
        check("way enable", s2_v ? s2_rq : 3, {28'h0, data_way_en}, {28'h0, exp_en}); // R3 R4
        check("one enable", 11, 32'($countones(data_way_en) <= 1), 32'd1);            // R11
        check("rsp_valid", r_v ? r_rq : 2, {31'h0, rsp_valid}, {31'h0, r_v});          // R2
        if (r_v) begin
            check("rsp_hit", r_rq, {31'h0, rsp_hit}, {31'h0, r_hit});
            check("rsp_rdata", r_rq, rsp_rdata, r_data);
            check("fwd_valid", r_rq, {31'h0, fwd_valid}, {31'h0, r_fwd});
            if (r_exph >= 0) check("table hit", r_rq, {31'h0, rsp_hit}, 32'(r_exph));
        end
        req_valid = rv; req_we = rw; req_addr = ra; req_wdata = wd; req_strb = sb;
        refill_valid = fv; refill_addr = fa;
        for (int k = 0; k < 4; k++) refill_line[32*k +: 32] = seed + 32'(k) * 32'h01010101;
        // retire stage two
        r_v = s2_v; r_hit = s2_v && (s2_way >= 0); r_fwd = 0; r_data = '0;
        r_rq = s2_rq; r_exph = s2_exph;
        if (r_hit) begin
            if (!s2_st) begin
                r_data = m_data[s2_way][s2_idx][s2_word];
                r_fwd = 1;
            end else begin
                for (int b = 0; b < 4; b++)
                    if (s2_sb[b]) m_data[s2_way][s2_idx][s2_word][8*b +: 8] = s2_wd[8*b +: 8];
            end
        end
        // refill
        if (fv) begin
            fi = int'(fa[7:4]);
            w = m_ptr[fi];
            m_tag[w][fi] = fa[31:8];
            m_vld[w][fi] = 1'b1;
            for (int k = 0; k < 4; k++) m_data[w][fi][k] = seed + 32'(k) * 32'h01010101;
            m_ptr[fi] = (w + 1) % 4;
        end
        // stage one lookup
        s2_v = rv; s2_st = rw; s2_way = -1; s2_idx = int'(ra[7:4]); s2_word = int'(ra[3:2]);
        s2_wd = wd; s2_sb = sb; s2_rq = rq; s2_exph = exph;
        if (rv)
            for (int k = 0; k < 4; k++)
                if (m_vld[k][s2_idx] && m_tag[k][s2_idx] == ra[31:8]) s2_way = k;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("rsp_valid in reset", 1, {31'h0, rsp_valid}, 32'd0);     // R1
        check("enable in reset", 1, {28'h0, data_way_en}, 32'd0);       // R1
        rst_n = 1'b1;
    endtask

    // op: 0 idle, 1 load, 2 store, 3 refill; exph: 0 miss, 1 hit, 2 unchecked
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [1:0]  exph;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 32'h0000_1010, 32'h0,         4'h0, 2'd0, 4'd1},  // R1 cold miss
        '{2'd3, 32'h0000_1010, 32'h1000_0000, 4'h0, 2'd2, 4'd8},  // R8 way 0
        '{2'd1, 32'h0000_1014, 32'h0,         4'h0, 2'd1, 4'd5},  // R5 word 1
        '{2'd2, 32'h0000_1018, 32'hAABB_CCDD, 4'h5, 2'd1, 4'd6},  // R6 partial store
        '{2'd1, 32'h0000_1018, 32'h0,         4'h0, 2'd1, 4'd9},  // R9 back to back
        '{2'd2, 32'h0000_2010, 32'h1111_1111, 4'hF, 2'd0, 4'd7},  // R7 store miss
        '{2'd1, 32'h0000_2010, 32'h0,         4'h0, 2'd0, 4'd7},  // R7 no allocate
        '{2'd3, 32'h0000_2010, 32'h2000_0000, 4'h0, 2'd2, 4'd8},  // R8 way 1
        '{2'd3, 32'h0000_3010, 32'h3000_0000, 4'h0, 2'd2, 4'd8},  // R8 way 2
        '{2'd3, 32'h0000_4010, 32'h4000_0000, 4'h0, 2'd2, 4'd8},  // R8 way 3
        '{2'd1, 32'h0000_301C, 32'h0,         4'h0, 2'd1, 4'd3},  // R3 way 2 enable
        '{2'd3, 32'h0000_5010, 32'h5000_0000, 4'h0, 2'd2, 4'd8},  // R8 evicts way 0
        '{2'd1, 32'h0000_1010, 32'h0,         4'h0, 2'd0, 4'd8},  // R8 evicted line
        '{2'd1, 32'h0000_5010, 32'h0,         4'h0, 2'd1, 4'd3},  // R3 way 0 again
        '{2'd0, 32'h0,         32'h0,         4'h0, 2'd2, 4'd2},
        '{2'd1, 32'h0000_2010, 32'h0,         4'h0, 2'd1, 4'd5},  // R5 way 1
        '{2'd2, 32'h0000_4010, 32'hDEAD_BEEF, 4'hF, 2'd1, 4'd6},  // R6 full store
        '{2'd1, 32'h0000_4010, 32'h0,         4'h0, 2'd1, 4'd9},  // R9
        '{2'd1, 32'h0000_1020, 32'h0,         4'h0, 2'd0, 4'd4},  // R4 other set
        '{2'd2, 32'h0000_2014, 32'hFFFF_FFFF, 4'h0, 2'd1, 4'd6},  // R6 no strobes
        '{2'd1, 32'h0000_2014, 32'h0,         4'h0, 2'd1, 4'd6},  // R6 unchanged
        '{2'd0, 32'h0,         32'h0,         4'h0, 2'd2, 4'd2},
        '{2'd0, 32'h0,         32'h0,         4'h0, 2'd2, 4'd2}
    };

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            step(v.op == 2'd1 || v.op == 2'd2, v.op == 2'd2, v.addr, v.data, v.strb,
                 v.op == 2'd3, v.addr, v.data, int'(v.rq),
                 (v.op == 2'd3 || v.op == 2'd0) ? -1 : int'(v.exph));
        end
        // R10: refill and load to the same line in one cycle
        step(1, 0, 32'h0000_7038, '0, '0, 1, 32'h0000_7030, 32'h7000_0000, 10, 1);
        step(0, 0, '0, '0, '0, 0, '0, '0, 10, -1);
        step(0, 0, '0, '0, '0, 0, '0, '0, 10, -1);
        // R1: reset mid-run clears the installed lines
        do_reset();
        step(1, 0, 32'h0000_5010, '0, '0, 0, '0, '0, 1, 0);
        step(1, 0, 32'h0000_7038, '0, '0, 0, '0, '0, 1, 0);
        step(0, 0, '0, '0, '0, 0, '0, '0, 1, -1);
        step(0, 0, '0, '0, '0, 0, '0, '0, 1, -1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule